// File: doc/BRIEF.md
# Dual-Source Video Capture Front End

This block connects a camera to the parallel data port of a processor. It takes one of two pixel sources. The first is the output of an external 10-bit video converter. The second is a native 14-bit digital pixel stream. It registers the chosen pixel and presents it on a 14-bit bus together with a one-cycle valid strobe. It also raises a line-start pulse and a frame-start pulse that the processor uses as interrupts. A sync separator, the differential receivers and the converter all sit outside the block, so their outputs arrive here as plain logic-level inputs.

The block runs on a fast master clock. It derives the pixel sample enable internally, one enable every `DIV` master cycles (4 by default, which gives 12 MHz from 48 MHz). The divider phase restarts at each line start, so the first sample of a line always lands at the same offset from the sync edge. A frame has `PIX_PER_LINE` pixels per line (320 by default) and `LINES` lines (240 by default).

The source choice is taken once per frame and held for the rest of that frame. A run/stop input gates the valid strobes. The pixel bus is released to high impedance whenever a boot memory shares the processor port.

Top module: `vcap_front_end`

## Requirements
- R1: During and right after reset, `pix_vld_o`, `line_irq_o` and `frame_irq_o` are 0, the held pixel is 0, and the source is digital.
- R2: A rising edge on `hsync_i` produces a single-cycle high pulse on `line_irq_o`. The pulse is high in the second clock cycle after the first edge that samples `hsync_i` high. Keeping `hsync_i` high produces no further pulse.
- R3: A rising edge on `vsync_i` produces a single-cycle pulse on `frame_irq_o` with the same timing as R2, and `line_irq_o` pulses in that same cycle.
- R4: After a line start, the first `pix_vld_o` pulse comes exactly `DIV` cycles after the `line_irq_o` pulse. Each later pulse in the line follows the previous one by exactly `DIV` cycles. Each pulse lasts one cycle.
- R5: In an open line with capture running, exactly `PIX_PER_LINE` valid pulses are issued, and then none until the next line start.
- R6: The line opened by a `vsync_i` rise is row 0, and each `hsync_i` rise advances the row. Rows at or beyond `LINES` within a frame produce no valid pulses, although `line_irq_o` still pulses for them.
- R7: With the digital source (select value 0), the pixel shown with a valid pulse equals the 14-bit `cam_pix_i` sampled at the sample-enable edge.
- R8: With the analog source (select value 1), the pixel equals `adc_word_i[9:2]` in bits 7:0, and bits 13:8 are 0.
- R9: `src_sel_i` is sampled only at a frame start. Changing it in the middle of a frame has no effect on the pixels of that frame.
- R10: Sample-enable edges with `run_i` low produce no valid pulse and leave the held pixel unchanged.
- R11: While `boot_sel_i` is 1, all bits of `pix_o` are high impedance. When `boot_sel_i` returns to 0, the held pixel appears again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (DIV times the pixel rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 = capture running, 0 = stopped |
| src_sel_i | input | 1 | Source choice: 0 digital, 1 analog; taken at frame start |
| adc_word_i | input | 10 | Converter output word |
| cam_pix_i | input | 14 | Native digital pixel |
| hsync_i | input | 1 | Separated line sync, active high |
| vsync_i | input | 1 | Separated frame sync, active high |
| boot_sel_i | input | 1 | Boot memory owns the shared bus; floats `pix_o` |
| pix_o | output | 14 | Registered pixel, tri-stated while `boot_sel_i` is 1 |
| pix_vld_o | output | 1 | One-cycle strobe for each captured pixel |
| line_irq_o | output | 1 | Line-start pulse |
| frame_irq_o | output | 1 | Frame-start pulse |

## Verification
The bench drives several kinds of frame:
- A digital frame in which the select input flips after the first line. This shows whether the source is latched at frame start or followed live.
- An analog frame, whose expected values use only the top converter bits. This separates correct truncation and zero-extension from a shifted or sign-extended mapping.
- An extra line past the row limit, which shows whether the row counter closes the window or keeps opening lines.
- A stopped line, which shows whether the run control gates the strobes.

Pixel patterns change at every sample. Strobe spacing is measured in cycles from the line pulse, so an off-by-one in the divider or the window count shows up as a wrong interval or a wrong number of strobes.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    // Pixel source choice, taken once per frame.
    typedef enum logic {
        SRC_DIGITAL = 1'b0,
        SRC_ANALOG  = 1'b1
    } vcap_src_e;

endpackage

// File: rtl/vcap_sync_edge.sv
// Two-stage sampler for one sync line; reports a rising edge for one cycle.
module vcap_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic rise_o
);
    typedef struct packed {
        logic cur;
        logic prev;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cur  = sync_i;
        st_d.prev = st_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.cur & ~st_q.prev;
endmodule

// File: rtl/vcap_tick_div.sv
// Pixel-rate enable from the master clock: one tick every DIV cycles,
// phase restarted by restart_i.
module vcap_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] CNT_LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == CNT_LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)  cnt_d = '0;
        else if (wrap)  cnt_d = '0;
        else            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = wrap & ~restart_i;
endmodule

// File: rtl/vcap_pix_mux.sv
// Chooses the pixel source and widens the converter sample.
module vcap_pix_mux
    import vcap_pkg::*;
#(
    parameter int PIX_W    = 14,
    parameter int ADC_W    = 10,
    parameter int ADC_KEEP = 8
) (
    input  vcap_src_e              src_i,
    input  logic [PIX_W-1:0]       cam_i,
    input  logic [ADC_W-1:0]       adc_i,
    output logic [PIX_W-1:0]       pix_o
);
    localparam int PAD_W  = PIX_W - ADC_KEEP;
    localparam int DROP_W = ADC_W - ADC_KEEP;

    logic [ADC_KEEP-1:0] adc_top;
    logic [PIX_W-1:0]    adc_wide;
    logic                unused_adc_lsbs;

    assign adc_top         = adc_i[ADC_W-1 -: ADC_KEEP];
    assign adc_wide        = {{PAD_W{1'b0}}, adc_top};
    assign unused_adc_lsbs = ^adc_i[DROP_W-1:0];

    always_comb begin
        unique case (src_i)
            SRC_ANALOG:  pix_o = adc_wide;
            default:     pix_o = cam_i;
        endcase
    end
endmodule

// File: rtl/vcap_front_end.sv
module vcap_front_end
    import vcap_pkg::*;
#(
    parameter int PIX_W        = 14,
    parameter int ADC_W        = 10,
    parameter int ADC_KEEP     = 8,
    parameter int PIX_PER_LINE = 320,
    parameter int LINES        = 240,
    parameter int DIV          = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              src_sel_i,
    input  logic [ADC_W-1:0]  adc_word_i,
    input  logic [PIX_W-1:0]  cam_pix_i,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic              boot_sel_i,
    output logic [PIX_W-1:0]  pix_o,
    output logic              pix_vld_o,
    output logic              line_irq_o,
    output logic              frame_irq_o
);
    localparam int COL_W = $clog2(PIX_PER_LINE + 1);
    localparam int ROW_W = $clog2(LINES + 1);
    localparam logic [COL_W-1:0] COL_LAST  = COL_W'(PIX_PER_LINE - 1);
    localparam logic [ROW_W-1:0] ROW_LAST  = ROW_W'(LINES - 1);
    localparam logic [ROW_W-1:0] ROW_LIMIT = ROW_W'(LINES);

    typedef struct packed {
        logic             line_irq;
        logic             frame_irq;
        vcap_src_e        src;
        logic             active;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic [PIX_W-1:0] pix;
        logic             vld;
    } cap_state_t;

    cap_state_t st_d, st_q;

    logic             h_rise, v_rise, line_start, tick;
    logic [PIX_W-1:0] mux_pix;
    logic             src_q;

    // Sync edge detection: one instance per sync line.
    logic [1:0] sync_in, sync_rise;
    assign sync_in = {vsync_i, hsync_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        vcap_sync_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_i (sync_in[g]),
            .rise_o (sync_rise[g])
        );
    end

    assign h_rise     = sync_rise[0];
    assign v_rise     = sync_rise[1];
    assign line_start = h_rise | v_rise;

    vcap_tick_div #(.DIV(DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (line_start),
        .tick_o    (tick)
    );

    vcap_pix_mux #(
        .PIX_W    (PIX_W),
        .ADC_W    (ADC_W),
        .ADC_KEEP (ADC_KEEP)
    ) u_mux (
        .src_i (st_q.src),
        .cam_i (cam_pix_i),
        .adc_i (adc_word_i),
        .pix_o (mux_pix)
    );

    always_comb begin
        st_d           = st_q;
        st_d.vld       = 1'b0;
        st_d.line_irq  = line_start;
        st_d.frame_irq = v_rise;

        if (v_rise) begin
            // Frame start: take the source, open row 0.
            st_d.src    = vcap_src_e'(src_sel_i);
            st_d.row    = '0;
            st_d.col    = '0;
            st_d.active = 1'b1;
        end else if (h_rise) begin
            st_d.col    = '0;
            st_d.active = (st_q.row < ROW_LAST);
            if (st_q.row != ROW_LIMIT) st_d.row = st_q.row + 1'b1;
        end else if (tick && st_q.active) begin
            st_d.col = st_q.col + 1'b1;
            if (st_q.col == COL_LAST) st_d.active = 1'b0;
            if (run_i) begin
                st_d.vld = 1'b1;
                st_d.pix = mux_pix;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_q       = st_q.src;
    assign pix_o       = boot_sel_i ? {PIX_W{1'bz}} : st_q.pix;
    assign pix_vld_o   = st_q.vld;
    assign line_irq_o  = st_q.line_irq;
    assign frame_irq_o = st_q.frame_irq;
endmodule

// File: rtl/vcap_front_end_chk.sv
module vcap_front_end_chk #(
    parameter int PIX_W    = 14,
    parameter int ADC_KEEP = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_i,
    input logic             boot_sel_i,
    input logic [PIX_W-1:0] pix_o,
    input logic             pix_vld_o,
    input logic             line_irq_o,
    input logic             frame_irq_o,
    input logic             src_q
);
    // R2: the line pulse never lasts two cycles
    a_r2_line_single: assert property (@(posedge clk) disable iff (!rst_n)
        line_irq_o |=> !line_irq_o);

    // R3: a frame pulse is also a line pulse
    a_r3_frame_is_line: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq_o |-> line_irq_o);

    // R4: valid strobes are single cycles
    a_r4_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld_o |=> !pix_vld_o);

    // R10: a strobe only follows a sample taken while running
    a_r10_run_gate: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld_o |-> $past(run_i));

    // R9: the held source changes only together with a frame pulse
    a_r9_src_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q != $past(src_q)) |-> frame_irq_o);

    // R8: analog pixels carry zeros above the kept converter bits
    a_r8_analog_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld_o && src_q && !boot_sel_i) |-> (pix_o[PIX_W-1:ADC_KEEP] == '0));
endmodule

bind vcap_front_end vcap_front_end_chk #(
    .PIX_W    (PIX_W),
    .ADC_KEEP (ADC_KEEP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_i),
    .boot_sel_i  (boot_sel_i),
    .pix_o       (pix_o),
    .pix_vld_o   (pix_vld_o),
    .line_irq_o  (line_irq_o),
    .frame_irq_o (frame_irq_o),
    .src_q       (src_q)
);

// File: tb/tb_vcap_front_end.sv
`timescale 1ns/1ps
module tb_vcap_front_end;
    localparam int PIX_W = 14;
    localparam int ADC_W = 10;
    localparam int NPIX  = 16;
    localparam int NLIN  = 4;
    localparam int DIV   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run = 1'b1;
    logic             src_sel = 1'b0;
    logic [ADC_W-1:0] adc = '0;
    logic [PIX_W-1:0] cam = '0;
    logic             hs = 1'b0;
    logic             vs = 1'b0;
    logic             boot = 1'b0;
    tri1  [PIX_W-1:0] pix_bus;
    logic             vld, lirq, firq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int strobes = 0;
    int irq_cyc = 0;
    int last_cyc = 0;
    bit first_in_line = 1'b0;
    bit bench_analog = 1'b0;
    logic [PIX_W-1:0] exp_q[$];
    logic [PIX_W-1:0] last_exp = '0;

    always #2 clk = ~clk;

    vcap_front_end #(
        .PIX_PER_LINE (NPIX),
        .LINES        (NLIN),
        .DIV          (DIV)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .src_sel_i   (src_sel),
        .adc_word_i  (adc),
        .cam_pix_i   (cam),
        .hsync_i     (hs),
        .vsync_i     (vs),
        .boot_sel_i  (boot),
        .pix_o       (pix_bus),
        .pix_vld_o   (vld),
        .line_irq_o  (lirq),
        .frame_irq_o (firq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: timing and scoreboard comparison of each strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (lirq) begin
                irq_cyc = cyc;
                first_in_line = 1'b1;
            end
            if (vld) begin
                strobes++;
                if (first_in_line) chk("R4 first strobe offset", cyc - irq_cyc, DIV);
                else               chk("R4 strobe spacing", cyc - last_cyc, DIV);
                first_in_line = 1'b0;
                last_cyc = cyc;
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected strobe", 1, 0);
                end else begin
                    logic [PIX_W-1:0] e;
                    e = exp_q.pop_front();
                    chk(bench_analog ? "R8 analog pixel" : "R7 digital pixel", pix_bus, e);
                end
            end
        end
    end

    // Driver: one line; caller is at a negedge.
    task automatic drive_line(input bit is_frame, input bit open_exp, input int id);
        int n_exp = 0;
        if (is_frame) begin
            vs = 1'b1;
            bench_analog = src_sel;
        end else begin
            hs = 1'b1;
        end
        @(negedge clk);
        chk("R2 no early pulse", lirq, 0);
        @(negedge clk);
        chk("R2 line pulse", lirq, 1);
        chk("R3 frame pulse", firq, is_frame);
        @(negedge clk);
        chk("R2 pulse ends while sync held", lirq, 0);
        chk("R3 frame pulse ends", firq, 0);
        hs = 1'b0;
        vs = 1'b0;
        strobes = 0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < NPIX; k++) begin
            if (k > 0) repeat (DIV) @(negedge clk);
            cam = PIX_W'((id * 131 + k * 29 + 5) & 'h1FFF);
            adc = ADC_W'(id * 53 + k * 71 + 3);
            if (open_exp && run) begin
                last_exp = bench_analog ? {6'b0, adc[9:2]} : cam;
                exp_q.push_back(last_exp);
                n_exp++;
            end
        end
        repeat (8) @(negedge clk);
        chk(open_exp ? (run ? "R5 strobe count" : "R10 stopped count") : "R6 closed row count",
            strobes, n_exp);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        chk("R1 reset vld", vld, 0);
        chk("R1 reset line irq", lirq, 0);
        chk("R1 reset frame irq", firq, 0);
        chk("R1 reset pixel", pix_bus, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", {vld, lirq, firq}, 0);

        // Frame A: digital, select flips mid-frame (R9), row limit (R6)
        src_sel = 1'b0;
        drive_line(1, 1, 0);
        src_sel = 1'b1;
        drive_line(0, 1, 1);
        drive_line(0, 1, 2);
        drive_line(0, 1, 3);
        drive_line(0, 0, 4);
        chk("R9 queue drained", exp_q.size(), 0);

        // R11: bus floats under boot select, held pixel returns after
        boot = 1'b1;
        @(negedge clk);
        chk("R11 bus floated", pix_bus, {PIX_W{1'b1}});
        boot = 1'b0;
        @(negedge clk);
        chk("R11 pixel restored", pix_bus, last_exp);

        // Frame B: analog (R8), one stopped line (R10)
        src_sel = 1'b1;
        drive_line(1, 1, 10);
        run = 1'b0;
        drive_line(0, 1, 11);
        chk("R10 held pixel unchanged", pix_bus, last_exp);
        run = 1'b1;
        drive_line(0, 1, 12);

        // Frame C: back to digital
        src_sel = 1'b0;
        drive_line(1, 1, 20);
        drive_line(0, 1, 21);

        chk("R5 no leftover expected pixels", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule